// File: doc/BRIEF.md
# Configurable Two/Three-Wire Serial Interface Core

This core is a compact serial engine: one byte-wide shift register paired with an edge counter. Each clock edge advances the counter, so sixteen edges carry one full byte. The same datapath serves every wire mode. A 2-bit mode select sets how the three pads are driven. The pads can stay under plain port control, act as a three-wire data-out/data-in/clock interface, or act as an open-drain two-wire bus.

Software controls the core through register-style inputs. These are the mode, the clock-source select, a software clock strobe, write-one flag-clear strobes, a byte load and the port data and direction bits. The core returns, per pad, a drive enable and a drive level, plus a pull-up disable. In the two-wire modes, a start detector and clock-stretching logic can hold the clock line low. The line stays low until software has serviced the event.

The data and clock inputs work the same way in every mode. This means a byte can be shifted in from an external clock even while all outputs stay under port control.

Top module: `wire_serial_core`

## Requirements
- R1: With mode 00, each pad's enable equals its direction bit and each pad's level equals its port data bit (pad 0 = data/SDA, pad 1 = data out, pad 2 = clock/SCL).
- R2: With mode 01, pad 1 drives the shift register's most significant bit, its enable still equals direction bit 1, and pads 0 and 2 follow their port bits.
- R3: In modes 10 and 11, pad 0 level is 0 and pad 0 is enabled exactly when direction bit 0 is 1 and either the shift MSB or port data bit 0 is 0.
- R4: In modes 10 and 11, pad 2 level is 0 and pad 2 is enabled when direction bit 2 is 1 and either port data bit 2 is 0 or a hold is active.
- R5: In modes 10 and 11, a falling SDA while SCL is high (on synchronized copies) sets the start flag, and the start hold keeps pad 2 pulled low until a start-clear strobe.
- R6: In modes 00 and 01, with clock source 10 or 11 and the software strobe low, any clock-pin edge sets the start flag; the start detector is inactive in these modes, and clock edges set no flag in modes 10 and 11.
- R7: Every counting edge increments the 4-bit counter; a wrap from 15 to 0 sets the overflow flag; each flag clears on its write-one strobe.
- R8: In mode 11 only, a set overflow flag holds pad 2 low until the overflow-clear strobe; in mode 10 it does not.
- R9: With clock source 10 the register shifts in the synchronized SDA on rising clock edges, with 11 on falling edges; both edges count, and this works in mode 00 too.
- R10: The pull-up disable output is 1 in modes 10 and 11 and 0 otherwise.
- R11: With clock source 01, each software strobe counts one edge, and the shift happens on the strobe taken while the counter is odd.
- R12: A load strobe writes the load byte into the shift register and clears the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeSel | input | 2 | Wire mode: 00 off, 01 three-wire, 10 two-wire, 11 two-wire with overflow hold |
| clkSrc | input | 2 | Clock source: 00 none, 01 software strobe, 10 external rising shift, 11 external falling shift |
| swClk | input | 1 | Software clock strobe, one cycle |
| startClr | input | 1 | Write-one clear of the start flag |
| ovfClr | input | 1 | Write-one clear of the overflow flag |
| loadEn | input | 1 | Load strobe for the shift register |
| loadData | input | 8 | Byte written by the load strobe |
| portData | input | 3 | Port data bits for pads 0..2 |
| portDir | input | 3 | Port direction bits for pads 0..2 |
| sdaPin | input | 1 | Data pin input (pad 0) |
| sclPin | input | 1 | Clock pin input (pad 2) |
| padOe | output | 3 | Per-pad drive enable |
| padLevel | output | 3 | Per-pad drive level |
| pullDis | output | 1 | Forces pad pull-ups off |
| dataOut | output | 8 | Shift register contents |
| cntOut | output | 4 | Edge counter value |
| startFlag | output | 1 | Start / clock-edge flag |
| ovfFlag | output | 1 | Counter overflow flag |

## Verification
The assertions assume the following about the inputs: the flag-clear, load and software-clock strobes last one cycle, the mode and clock source hold steady while edges are counted, and the pin inputs change no faster than the two-stage synchronizer can follow. The bench holds every pin level for four cycles, changes SDA only while SCL is low unless a start is intended, and drives every strobe for a single cycle at the falling clock edge. It samples outputs only after the synchronizer and the flag registers have settled.

// File: rtl/serial_core_pkg.sv
package serial_core_pkg;

  typedef enum logic [1:0] {
    MODE_OFF      = 2'b00,
    MODE_THREE    = 2'b01,
    MODE_TWO      = 2'b10,
    MODE_TWO_HOLD = 2'b11
  } wireMode_t;

  typedef enum logic [1:0] {
    SRC_NONE     = 2'b00,
    SRC_SOFT     = 2'b01,
    SRC_EXT_RISE = 2'b10,
    SRC_EXT_FALL = 2'b11
  } clkSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;
    logic countEn;
    logic load;
  } dpStrobe_t;

  localparam int PIN_SDA = 0;
  localparam int PIN_DO  = 1;
  localparam int PIN_SCL = 2;
  localparam int PIN_N   = 3;

endpackage

// File: rtl/serial_pin_sync.sv
module serial_pin_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;   // idle bus level
        else       chain <= {chain[STAGES-2:0], din[i]};
      end
      assign dout[i] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/serial_ctrl.sv
module serial_ctrl
  import serial_core_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] modeSel,
  input  logic [1:0] clkSrc,
  input  logic      swClk,
  input  logic      loadEn,
  input  logic      startClr,
  input  logic      ovfClr,
  input  logic      sdaS,
  input  logic      sclS,
  input  logic      cntLsb,
  input  logic      ovfPulse,
  output dpStrobe_t strobe,
  output logic      startFlag,
  output logic      ovfFlag,
  output logic      sclHold
);

  logic sdaPrev, sclPrev;
  logic sclRise, sclFall, sclEdge;
  logic extSel, softSel, twoWire;
  logic startDet, edgeStart, setStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaPrev <= 1'b1;
      sclPrev <= 1'b1;
    end else begin
      sdaPrev <= sdaS;
      sclPrev <= sclS;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign sclEdge = sclRise | sclFall;

  assign extSel  = clkSrc[1];
  assign softSel = (clkSrc == SRC_SOFT);
  assign twoWire = modeSel[1];

  always_comb begin
    strobe.load    = loadEn;
    strobe.countEn = (extSel & sclEdge) | (softSel & swClk);
    if (extSel)
      strobe.shiftEn = (clkSrc == SRC_EXT_FALL) ? sclFall : sclRise;
    else
      strobe.shiftEn = softSel & swClk & cntLsb;
  end

  // start condition: SDA falls while SCL stays high
  assign startDet  = twoWire & sclS & sclPrev & sdaPrev & ~sdaS;
  assign edgeStart = ~twoWire & extSel & ~swClk & sclEdge;
  assign setStart  = startDet | edgeStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (setStart)      startFlag <= 1'b1;
      else if (startClr) startFlag <= 1'b0;
      if (ovfPulse)      ovfFlag <= 1'b1;
      else if (ovfClr)   ovfFlag <= 1'b0;
    end
  end

  assign sclHold = twoWire & (startFlag | ((modeSel == MODE_TWO_HOLD) & ovfFlag));

  // R5: the start flag stays set until cleared
  p_start_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    startFlag && !startClr |=> startFlag);

  // R6: an external clock edge in a non-bus mode raises the flag
  p_edge_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!modeSel[1] && clkSrc[1] && !swClk && (sclS != sclPrev)) |=> startFlag);

  // R7: overflow sets its flag, a lone clear drops it
  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |=> ovfFlag);
  p_ovf_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ovfClr && !ovfPulse |=> !ovfFlag);

endmodule

// File: rtl/serial_datapath.sv
module serial_datapath
  import serial_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic              dataIn,
  output logic [DATA_W-1:0] shiftReg,
  output logic [CNT_W-1:0]  cnt,
  output logic              ovfPulse
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      cnt      <= '0;
    end else if (strobe.load) begin
      shiftReg <= loadData;
      cnt      <= '0;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], dataIn};
      if (strobe.countEn) cnt <= cnt + 1'b1;
    end
  end

  assign ovfPulse = strobe.countEn & ~strobe.load & (cnt == CNT_MAX);

  // R7: each counting edge advances the counter by one
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countEn && !strobe.load |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R9: without a shift or load strobe the register holds
  p_shift_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn && !strobe.load |=> $stable(shiftReg));

  // R12: a load writes the byte and clears the counter
  p_load_r12: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (shiftReg == $past(loadData)) && (cnt == '0));

endmodule

// File: rtl/serial_pad_mux.sv
module serial_pad_mux
  import serial_core_pkg::*;
(
  input  logic [1:0]       modeSel,
  input  logic [PIN_N-1:0] portData,
  input  logic [PIN_N-1:0] portDir,
  input  logic             shiftMsb,
  input  logic             sclHold,
  output logic [PIN_N-1:0] padOe,
  output logic [PIN_N-1:0] padLevel,
  output logic             pullDis
);

  always_comb begin
    padOe    = portDir;
    padLevel = portData;
    pullDis  = 1'b0;
    case (modeSel)
      MODE_THREE: padLevel[PIN_DO] = shiftMsb;
      MODE_TWO, MODE_TWO_HOLD: begin
        pullDis           = 1'b1;
        padLevel[PIN_SDA] = 1'b0;
        padLevel[PIN_SCL] = 1'b0;
        padOe[PIN_SDA]    = portDir[PIN_SDA] & ~(shiftMsb & portData[PIN_SDA]);
        padOe[PIN_SCL]    = portDir[PIN_SCL] & (~portData[PIN_SCL] | sclHold);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/wire_serial_core.sv
module wire_serial_core
  import serial_core_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = $clog2(2 * DATA_W),
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        clkSrc,
  input  logic              swClk,
  input  logic              startClr,
  input  logic              ovfClr,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  input  logic [2:0]        portData,
  input  logic [2:0]        portDir,
  input  logic              sdaPin,
  input  logic              sclPin,
  output logic [2:0]        padOe,
  output logic [2:0]        padLevel,
  output logic              pullDis,
  output logic [DATA_W-1:0] dataOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic              startFlag,
  output logic              ovfFlag
);

  localparam int SDA_IDX = 0;
  localparam int SCL_IDX = 1;

  logic [1:0]  syncOut;
  dpStrobe_t   strobe;
  logic        ovfPulse, sclHold;

  serial_pin_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk (clk), .rstN (rstN),
    .din ({sclPin, sdaPin}),
    .dout(syncOut)
  );

  serial_ctrl u_ctrl (
    .clk      (clk),       .rstN    (rstN),
    .modeSel  (modeSel),   .clkSrc  (clkSrc),
    .swClk    (swClk),     .loadEn  (loadEn),
    .startClr (startClr),  .ovfClr  (ovfClr),
    .sdaS     (syncOut[SDA_IDX]), .sclS (syncOut[SCL_IDX]),
    .cntLsb   (cntOut[0]), .ovfPulse(ovfPulse),
    .strobe   (strobe),
    .startFlag(startFlag), .ovfFlag (ovfFlag),
    .sclHold  (sclHold)
  );

  serial_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),      .rstN    (rstN),
    .strobe  (strobe),   .loadData(loadData),
    .dataIn  (syncOut[SDA_IDX]),
    .shiftReg(dataOut),  .cnt     (cntOut),
    .ovfPulse(ovfPulse)
  );

  serial_pad_mux u_pad (
    .modeSel (modeSel),  .portData(portData),
    .portDir (portDir),  .shiftMsb(dataOut[DATA_W-1]),
    .sclHold (sclHold),
    .padOe   (padOe),    .padLevel(padLevel),
    .pullDis (pullDis)
  );

  // R2: three-wire data pad carries the shift MSB
  p_three_do_r2: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == MODE_THREE |-> padLevel[PIN_DO] == dataOut[DATA_W-1]);

  // R3: bus data line released when both sources are high
  p_sda_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] && dataOut[DATA_W-1] && portData[PIN_SDA] |-> !padOe[PIN_SDA]);

  // R5: a pending start holds the bus clock low
  p_start_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] && startFlag && portDir[PIN_SCL] |-> padOe[PIN_SCL] && !padLevel[PIN_SCL]);

  // R8: pending overflow in hold mode stretches the clock
  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    modeSel == MODE_TWO_HOLD && ovfFlag && portDir[PIN_SCL] |-> padOe[PIN_SCL]);

  // R10: pull-ups are off on the bus
  p_pull_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |-> pullDis);

endmodule

// File: tb/wire_serial_core_bench.sv
module wire_serial_core_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00, clkSrc = 2'b00;
  logic swClk = 1'b0, startClr = 1'b0, ovfClr = 1'b0, loadEn = 1'b0;
  logic [7:0] loadData = 8'h00;
  logic [2:0] portData = 3'b000, portDir = 3'b000;
  logic sdaPin = 1'b1, sclPin = 1'b0;
  logic [2:0] padOe, padLevel;
  logic pullDis, startFlag, ovfFlag;
  logic [7:0] dataOut;
  logic [3:0] cntOut;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wire_serial_core u_wire_serial_core (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .clkSrc(clkSrc),
    .swClk(swClk), .startClr(startClr), .ovfClr(ovfClr),
    .loadEn(loadEn), .loadData(loadData),
    .portData(portData), .portDir(portDir),
    .sdaPin(sdaPin), .sclPin(sclPin),
    .padOe(padOe), .padLevel(padLevel), .pullDis(pullDis),
    .dataOut(dataOut), .cntOut(cntOut),
    .startFlag(startFlag), .ovfFlag(ovfFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pins(input logic sda, input logic scl);
    @(negedge clk);
    sdaPin = sda;
    sclPin = scl;
    settle();
  endtask

  task automatic loadByte(input logic [7:0] b);
    @(negedge clk); loadData = b; loadEn = 1'b1;
    @(negedge clk); loadEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic clrFlags();
    @(negedge clk); startClr = 1'b1; ovfClr = 1'b1;
    @(negedge clk); startClr = 1'b0; ovfClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 reset start", startFlag, 0);
    check("R7 reset ovf", ovfFlag, 0);
    check("R7 reset cnt", cntOut, 0);
    check("R1 reset oe", padOe, 3'b000);
  endtask

  task automatic t_port_mode();
    modeSel = 2'b00; portDir = 3'b101; portData = 3'b011;
    settle();
    check("R1 oe", padOe, 3'b101);
    check("R1 level", padLevel, 3'b011);
    check("R10 pull off mode00", pullDis, 0);
  endtask

  task automatic t_three_wire();
    modeSel = 2'b01; clkSrc = 2'b00; portDir = 3'b010; portData = 3'b100;
    loadByte(8'hA5);
    check("R12 load", dataOut, 8'hA5);
    check("R2 do level", padLevel, 3'b110);
    check("R2 oe", padOe, 3'b010);
    loadByte(8'h25);
    check("R2 do low", padLevel[1], 0);
    check("R10 pull off mode01", pullDis, 0);
  endtask

  task automatic t_ext_rise();
    logic [7:0] pat;
    pat = 8'b1011_0010;
    modeSel = 2'b00; clkSrc = 2'b10; portDir = 3'b000;
    pins(1'b1, 1'b0);
    clrFlags();
    loadByte(8'h00);
    check("R6 no flag before edges", startFlag, 0);
    for (int i = 7; i >= 0; i--) begin
      pins(pat[i], 1'b0);
      pins(pat[i], 1'b1);
      pins(pat[i], 1'b0);
      if (i == 7) begin
        check("R7 two edges counted", cntOut, 2);
        check("R6 edge sets flag mode00", startFlag, 1);
      end
    end
    check("R9 rising shift mode00", dataOut, pat);
    check("R7 wrap to zero", cntOut, 0);
    check("R7 overflow set", ovfFlag, 1);
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    @(negedge clk);
    check("R7 overflow cleared", ovfFlag, 0);
    check("R7 start untouched by ovf clear", startFlag, 1);
    @(negedge clk); startClr = 1'b1;
    @(negedge clk); startClr = 1'b0;
    @(negedge clk);
    check("R7 start cleared", startFlag, 0);
  endtask

  task automatic t_ext_fall();
    logic [3:0] pat;
    pat = 4'b0110;
    modeSel = 2'b01; clkSrc = 2'b11;
    pins(1'b0, 1'b0);
    loadByte(8'h00);
    for (int i = 3; i >= 0; i--) begin
      pins(pat[i], 1'b0);
      pins(pat[i], 1'b1);
      if (i == 3) check("R9 no shift on rise", dataOut, 8'h00);
      pins(pat[i], 1'b0);
    end
    check("R9 falling shift", dataOut, 8'h06);
    check("R9 both edges counted", cntOut, 8);
    check("R6 edge flag mode01", startFlag, 1);
    clrFlags();
  endtask

  task automatic t_soft_clock();
    modeSel = 2'b00; clkSrc = 2'b01;
    pins(1'b0, 1'b0);
    clrFlags();
    loadByte(8'h81);
    @(negedge clk); swClk = 1'b1;
    @(negedge clk); swClk = 1'b0;
    @(negedge clk);
    check("R11 first strobe counts", cntOut, 1);
    check("R11 first strobe no shift", dataOut, 8'h81);
    @(negedge clk); swClk = 1'b1;
    @(negedge clk); swClk = 1'b0;
    @(negedge clk);
    check("R11 second strobe shifts", dataOut, 8'h02);
    check("R11 count two", cntOut, 2);
    pins(1'b0, 1'b1);
    check("R6 soft source edge no flag", startFlag, 0);
    check("R11 ext edge ignored", cntOut, 2);
    pins(1'b0, 1'b0);
  endtask

  task automatic t_no_detect_off();
    modeSel = 2'b00; clkSrc = 2'b00;
    pins(1'b1, 1'b1);
    pins(1'b0, 1'b1);
    check("R6 no start detect in mode00", startFlag, 0);
    pins(1'b1, 1'b0);
  endtask

  task automatic t_two_wire_start();
    clkSrc = 2'b00; portDir = 3'b101; portData = 3'b101;
    pins(1'b1, 1'b0);
    modeSel = 2'b10;
    loadByte(8'hFF);
    clrFlags();
    check("R10 pull disabled", pullDis, 1);
    check("R3 sda released", padOe[0], 0);
    check("R4 scl released", padOe[2], 0);
    portData = 3'b100;
    settle();
    check("R3 sda pulled by port bit", padOe[0], 1);
    check("R3 sda level low", padLevel[0], 0);
    portData = 3'b001;
    settle();
    check("R4 scl pulled by port bit", padOe[2], 1);
    portData = 3'b101;
    pins(1'b1, 1'b1);
    pins(1'b0, 1'b1);
    check("R5 start flag", startFlag, 1);
    check("R5 scl held", padOe[2], 1);
    check("R4 scl level low", padLevel[2], 0);
    pins(1'b0, 1'b0);
    check("R5 still held", padOe[2], 1);
    @(negedge clk); startClr = 1'b1;
    @(negedge clk); startClr = 1'b0;
    @(negedge clk);
    check("R5 released on clear", padOe[2], 0);
    check("R5 flag cleared", startFlag, 0);
  endtask

  task automatic run16(input logic [1:0] m);
    modeSel = m; clkSrc = 2'b10; portDir = 3'b101; portData = 3'b101;
    pins(1'b1, 1'b0);
    clrFlags();
    loadByte(8'hFF);
    for (int i = 0; i < 8; i++) begin
      pins(1'b1, 1'b1);
      pins(1'b1, 1'b0);
    end
  endtask

  task automatic t_ovf_hold();
    run16(2'b11);
    check("R8 overflow set mode11", ovfFlag, 1);
    check("R6 no edge flag in bus mode", startFlag, 0);
    check("R8 scl held on overflow", padOe[2], 1);
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    @(negedge clk);
    check("R8 released on clear", padOe[2], 0);
    run16(2'b10);
    check("R8 overflow set mode10", ovfFlag, 1);
    check("R8 no hold in mode10", padOe[2], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    t_reset();
    t_port_mode();
    t_three_wire();
    t_ext_rise();
    t_ext_fall();
    t_soft_clock();
    t_no_detect_off();
    t_two_wire_start();
    t_ovf_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule